// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core should take next. It watches one reset request line and a set of peripheral request lines. Each source has a fixed vector slot at the bottom of program memory. The reset request owns slot 0, and peripheral source i owns slot i+1. When the block accepts a source, it issues a one-cycle acknowledge on that source's bit and drives the matching vector address for the core to jump to. In hardware it also clears the global interrupt enable, so a handler runs unnested unless software turns the enable back on.

Peripheral requests are captured on their rising edge into pending flags. A pending flag stays set until that source is acknowledged, even while the source is disabled. The core can set or clear the global enable with write strobes, and a return-from-interrupt strobe sets it again. While the core reports that an instruction is still in progress, peripheral arbitration waits for the boundary. A reset request does not wait: it overrides every enable and the busy signal, and it wipes all pending flags.

The control is a two-state machine. In `ST_RUN` the block arbitrates every cycle. On the "accept" transition it latches the winning slot and moves to `ST_ISSUE`. `ST_ISSUE` drives the acknowledge and vector for exactly one cycle, then takes the "issue done" transition back to `ST_RUN`.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The vector address equals slot × SLOT_WORDS words. The reset request uses slot 0 and source i uses slot i+1. Acknowledge bit 0 belongs to reset and bit i+1 belongs to source i.
- R2: A peripheral source is accepted only when its pending flag, its enable bit and the global enable are all 1.
- R3: When several sources are eligible in the same cycle, the lowest slot number wins. The others stay pending.
- R4: On acceptance the global enable drops to 0 in the same edge. No further peripheral source is accepted until software sets it again.
- R5: A pulse on gie_set sets the global enable and a pulse on gie_clr clears it. If both strobes are high in the same cycle, the set wins.
- R6: A pulse on reti sets the global enable, which lets a still-pending source be taken afterwards.
- R7: A pending flag is set by a 0→1 change of its request line. A request held high does not set it again. The flag survives while its source is disabled, and it is cleared by that source's acknowledge.
- R8: A reset request is accepted whatever the enables and core_busy hold. It issues slot 0, leaves the global enable at 0 and clears every pending flag.
- R9: While core_busy is 1, no peripheral source is accepted. The source is accepted once core_busy returns to 0.
- R10: irq_pending is 1 in the cycle an acceptance happens. The acknowledge follows in the next cycle, is one-hot, and lasts exactly one cycle.
- R11: After rst_n is released, the global enable is 0, nothing is pending and no acknowledge is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| rst_req | input | 1 | Reset request, taken as slot 0 |
| irq_req | input | NUM_SRC | Peripheral request lines, edge-captured |
| irq_en | input | NUM_SRC | Per-source enable bits |
| gie_set | input | 1 | Write strobe setting the global enable |
| gie_clr | input | 1 | Write strobe clearing the global enable |
| reti | input | 1 | Return-from-interrupt strobe, sets the global enable |
| core_busy | input | 1 | Core is inside an instruction; holds off peripheral acceptance |
| gie | output | 1 | Current global enable state |
| irq_pending | output | 1 | An acceptance is taking place this cycle |
| vec_addr | output | ADDR_W | Vector address during the acknowledge cycle, else 0 |
| ack | output | NUM_SRC+1 | One-hot acknowledge pulse per slot (bit 0 = reset) |

## Verification
The bench raises two requests in the same cycle and then releases the lower-priority one only through reti. A design with reversed priority, or one that left the global enable set on entry, would deliver the wrong vector or two vectors back to back. It holds a request high across a handler, and it raises a request while its source is disabled. A level-triggered design would re-enter, and a design that dropped flags while disabled would never deliver the late one. A reset request is fired with every enable off, the core busy and a peripheral flag pending. The check is that only vector 0 appears and that the old flag is gone afterwards. The exact cycle of irq_pending and the acknowledge is also sampled, so an extra pipeline stage or a two-cycle pulse shows up as a mismatch.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_ISSUE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irq_edge_flags.sv
module irq_edge_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] clr_one,
    input  logic         clr_all,
    output logic [N-1:0] pend
);
    logic [N-1:0] req_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
                pend[g]  <= 1'b0;
            end else begin
                req_q[g] <= req[g];
                if (clr_all)
                    pend[g] <= 1'b0;
                else if (req[g] && !req_q[g])
                    pend[g] <= 1'b1;
                else if (clr_one[g])
                    pend[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 7,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int NUM_SRC    = 6,
    parameter int ADDR_W     = 8,
    parameter int SLOT_WORDS = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_req,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               reti,
    input  logic               core_busy,
    output logic               gie,
    output logic               irq_pending,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic [NUM_SRC:0]   ack
);
    localparam int NSLOT = NUM_SRC + 1;
    localparam int IDX_W = $clog2(NSLOT);

    irq_state_e         state_q, state_d;
    logic [IDX_W-1:0]   win_q;
    logic               rst_pend_q;
    logic [NUM_SRC-1:0] pend;
    logic [NSLOT-1:0]   cand;
    logic               found;
    logic [IDX_W-1:0]   pick;
    logic               accept;

    irq_edge_flags #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req),
        .clr_one (ack[NSLOT-1:1]),
        .clr_all (ack[0]),
        .pend    (pend)
    );

    assign cand = {pend & irq_en & {NUM_SRC{gie && !core_busy}}, rst_pend_q};

    irq_prio_pick #(.N(NSLOT), .IDX_W(IDX_W)) u_pick (
        .cand  (cand),
        .found (found),
        .idx   (pick)
    );

    assign accept = (state_q == ST_RUN) && found;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (found) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // state register and the registers it steers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_RUN;
            win_q      <= '0;
            gie        <= 1'b0;
            rst_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)
                win_q <= pick;
            if (accept)
                gie <= 1'b0;
            else if (gie_set || reti)
                gie <= 1'b1;
            else if (gie_clr)
                gie <= 1'b0;
            if (rst_req)
                rst_pend_q <= 1'b1;
            else if (ack[0])
                rst_pend_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        ack         = '0;
        vec_addr    = '0;
        irq_pending = 1'b0;
        unique case (state_q)
            ST_RUN: irq_pending = found;
            ST_ISSUE: begin
                ack[win_q] = 1'b1;
                vec_addr   = ADDR_W'(win_q) * ADDR_W'(SLOT_WORDS);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
    parameter int NUM_SRC = 6,
    parameter int ADDR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gie,
    input logic              irq_pending,
    input logic              reti,
    input logic              core_busy,
    input logic              rst_pend,
    input logic [NUM_SRC:0]  ack,
    input logic [ADDR_W-1:0] vec_addr
);
    // R10
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |=> (ack == '0));

    // R4
    entry_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |-> !gie);

    // R2
    src_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack[NUM_SRC:1]) |-> $past(gie));

    // R6
    reti_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !irq_pending) |=> gie);

    // R9
    busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_busy && !rst_pend) |=> (ack[NUM_SRC:1] == '0));

    // R1
    reset_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack[0] |-> (vec_addr == '0));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .gie         (gie),
    .irq_pending (irq_pending),
    .reti        (reti),
    .core_busy   (core_busy),
    .rst_pend    (rst_pend_q),
    .ack         (ack),
    .vec_addr    (vec_addr)
);

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 6;
    localparam int AW = 8;
    localparam int SW = 1;

    typedef struct {
        string       tag;
        logic [NS:0] ack;
        logic [AW-1:0] vec;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_req = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic [NS-1:0] irq_en = '0;
    logic          gie_set = 1'b0, gie_clr = 1'b0, reti = 1'b0, core_busy = 1'b0;
    logic          gie, irq_pending;
    logic [AW-1:0] vec_addr;
    logic [NS:0]   ack;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_vec_ctrl #(.NUM_SRC(NS), .ADDR_W(AW), .SLOT_WORDS(SW)) u_irq_vec_ctrl (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_req(irq_req),
        .irq_en(irq_en), .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
        .core_busy(core_busy), .gie(gie), .irq_pending(irq_pending),
        .vec_addr(vec_addr), .ack(ack)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_slot(input int slot, input string tag);
        exp_t e;
        e.tag = tag;
        e.ack = '0;
        e.ack[slot] = 1'b1;
        e.vec = AW'(slot * SW);
        exp_q.push_back(e);
    endtask

    task automatic drain(input string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // monitor: every acknowledge is matched against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done && ack != '0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R4 unexpected ack", int'(ack), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(ack == e.ack, {e.tag, " ack"}, int'(ack), int'(e.ack));
                check(vec_addr == e.vec, {e.tag, " vec"}, int'(vec_addr), int'(e.vec));
            end
        end
    end

    task automatic pulse_set();
        gie_set = 1'b1; tick(1); gie_set = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R11 reset state
        check(gie == 1'b0, "R11 gie", gie, 0);
        check(irq_pending == 1'b0, "R11 pending", irq_pending, 0);
        check(ack == '0, "R11 ack", int'(ack), 0);

        // R2: enabled source waits for global enable
        irq_en = 6'b000100;
        irq_req[2] = 1'b1;
        tick(6);
        check(irq_pending == 1'b0, "R2 no gie", irq_pending, 0);
        expect_slot(3, "R2");
        pulse_set();
        tick(4);
        drain("R2 delivered");
        check(gie == 1'b0, "R4 cleared on entry", gie, 0);
        irq_req = '0;

        // R3: two at once, lower slot first; second waits for reti (R6)
        irq_en = '1;
        irq_req[1] = 1'b1;
        irq_req[4] = 1'b1;
        tick(3);
        expect_slot(2, "R3");
        pulse_set();
        tick(5);
        drain("R3 first");
        check(gie == 1'b0, "R4 after R3 entry", gie, 0);
        tick(5);
        expect_slot(5, "R6");
        reti = 1'b1; tick(1); reti = 1'b0;
        tick(5);
        drain("R6 second");
        irq_req = '0;

        // R7: held level does not retrigger
        irq_req[0] = 1'b1;
        expect_slot(1, "R7 first edge");
        pulse_set();
        tick(5);
        drain("R7 first");
        pulse_set();
        tick(6);
        check(gie == 1'b1, "R5 set held", gie, 1);
        irq_req[0] = 1'b0;
        tick(1);
        expect_slot(1, "R7 new edge");
        irq_req[0] = 1'b1;
        tick(5);
        drain("R7 new edge");
        irq_req = '0;

        // R7: flag kept while disabled
        irq_en = '0;
        pulse_set();
        irq_req[3] = 1'b1;
        tick(5);
        check(irq_pending == 1'b0, "R2 disabled", irq_pending, 0);
        irq_req[3] = 1'b0;
        expect_slot(4, "R7 retained");
        irq_en[3] = 1'b1;
        tick(5);
        drain("R7 retained");

        // R5 write strobes
        pulse_set();
        check(gie == 1'b1, "R5 set", gie, 1);
        gie_clr = 1'b1; tick(1); gie_clr = 1'b0;
        check(gie == 1'b0, "R5 clr", gie, 0);
        gie_set = 1'b1; gie_clr = 1'b1; tick(1);
        gie_set = 1'b0; gie_clr = 1'b0;
        check(gie == 1'b1, "R5 set wins", gie, 1);

        // R9: busy holds off
        irq_en = '1;
        core_busy = 1'b1;
        irq_req[5] = 1'b1;
        tick(6);
        check(irq_pending == 1'b0, "R9 busy", irq_pending, 0);
        expect_slot(6, "R9");
        core_busy = 1'b0;
        tick(5);
        drain("R9 after busy");
        irq_req = '0;

        // R10 exact timing
        pulse_set();
        irq_req[0] = 1'b1;
        expect_slot(1, "R10");
        tick(1);
        check(irq_pending == 1'b1, "R10 pending cycle", irq_pending, 1);
        check(ack == '0, "R10 no early ack", int'(ack), 0);
        tick(1);
        check(ack == 7'b0000010, "R10 ack cycle", int'(ack), 2);
        check(gie == 1'b0, "R4 gie in ack cycle", gie, 0);
        tick(1);
        check(ack == '0, "R10 one cycle", int'(ack), 0);
        drain("R10");
        irq_req = '0;

        // R8: reset request overrides everything and wipes flags
        irq_en = '0;
        core_busy = 1'b1;
        irq_req[1] = 1'b1;
        tick(3);
        expect_slot(0, "R8");
        rst_req = 1'b1; tick(1); rst_req = 1'b0;
        tick(5);
        drain("R8 reset taken");
        check(gie == 1'b0, "R8 gie", gie, 0);
        core_busy = 1'b0;
        irq_en = '1;
        pulse_set();
        tick(6);
        check(irq_pending == 1'b0, "R8 flags wiped", irq_pending, 0);
        drain("R8 nothing after");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule